// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Thresholds

This block carries 36-bit words from a producer clock domain to a consumer clock domain through a 64-entry buffer. The two clocks run freely. They may be unrelated or they may be the same clock. A producer stores a word on a rising edge of its clock whenever its write enable is high and the buffer is not full. A consumer takes the oldest word on a rising edge of its clock whenever its read enable is high and the buffer is not empty. The word it takes is presented on a registered output.

Each side sees only flags that are already in its own clock domain. The producer side reports full and almost-full. The consumer side reports empty and almost-empty. Pointers cross between the domains as Gray code through two flip-flop stages, so a flag can be pessimistic for a few cycles but is never optimistic. Each side holds its own warning threshold. The threshold comes up at 8 on reset, and a one-cycle load strobe on that side replaces it while the block runs.

Top module: `dual_clock_fifo_thr`

## Requirements
- R1: While a side is in reset, and after reset, empty and almost_empty read 1, full and almost_full read 0, and rd_data reads 0.
- R2: Words leave in the order they were accepted, with all 36 bits intact, and up to 64 words are held at once.
- R3: full is 1 once 64 words are stored. A write while full is ignored: the word is never delivered, and no stored word is lost.
- R4: A read while empty is ignored: rd_data keeps its value and the read pointer does not move.
- R5: With both clocks the same, empty is evaluated against the write count as it stood three edges earlier, and full against the read count as it stood three edges earlier. Each side's own transfers take effect on the very edge they happen.
- R6: almost_empty is 1 when the stored count seen by the read side is at or below the read-side threshold.
- R7: almost_full is 1 when the free space seen by the write side (64 minus the stored count) is at or below the write-side threshold.
- R8: Both thresholds are 7-bit unsigned values that reset to 8. A high af_load (write clock) or ae_load (read clock) stores af_value or ae_value, and the flag uses the new value from the next edge on.
- R9: rd_data changes only on an edge that accepts a read, and it then shows the word taken on that edge.
- R10: With unrelated clocks, every accepted word arrives once and in order, and the crossing pointer changes at most one bit per write-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| wr_rst_n | input | 1 | Producer-side reset, active low, asynchronous assert |
| wr_en | input | 1 | Store wr_data on this edge if not full |
| wr_data | input | 36 | Word to store |
| af_load | input | 1 | Replace almost-full threshold |
| af_value | input | 7 | New almost-full threshold (free words) |
| full | output | 1 | No free entry |
| almost_full | output | 1 | Free entries at or below threshold |
| rd_clk | input | 1 | Consumer clock |
| rd_rst_n | input | 1 | Consumer-side reset, active low, asynchronous assert |
| rd_en | input | 1 | Take the oldest word on this edge if not empty |
| ae_load | input | 1 | Replace almost-empty threshold |
| ae_value | input | 7 | New almost-empty threshold (stored words) |
| rd_data | output | 36 | Last word taken, registered |
| empty | output | 1 | No stored word |
| almost_empty | output | 1 | Stored words at or below threshold |

## Verification
When both clocks are the same, a side's own transfer shows in its flags and in rd_data right after the edge that performs it. A transfer from the opposite side reaches a flag on the third edge after it: one edge for the pointer register and two for the synchronizer. The reference model keeps a three-deep history of both transfer counts, so each prediction uses the count that is due. The outputs are sampled 2 ns after every edge, with the inputs already stable. With unrelated clocks, no latency is predicted. Each side instead samples its own flag one nanosecond after its edge to decide whether its next transfer will be accepted, and the words are compared in order.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
    localparam int unsigned DCF_DEPTH     = 64;
    localparam int unsigned DCF_WIDTH     = 36;
    localparam int unsigned DCF_OFS_RESET = 8;

    function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction
endpackage

// File: rtl/dcf_sync2.sv
module dcf_sync2 #(
    parameter int unsigned W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned WIDTH = 36,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             wclk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side #(
    parameter int unsigned DEPTH     = 64,
    parameter int unsigned OFS_RESET = 8,
    localparam int unsigned PW       = $clog2(DEPTH) + 1,
    localparam int unsigned AW       = PW - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          ofs_load,
    input  logic [PW-1:0] ofs_value,
    input  logic [PW-1:0] rd_gray_x,
    output logic [PW-1:0] wr_gray,
    output logic [AW-1:0] wr_addr,
    output logic          wr_accept,
    output logic          full,
    output logic          almost_full
);
    import dcf_pkg::*;

    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic [PW-1:0] ofs;
        logic          full;
        logic          afull;
    } wr_state_t;

    wr_state_t     st_d, st_q;
    logic [PW-1:0] rd_gray_s;
    logic [PW-1:0] rd_bin_s;
    logic [PW-1:0] used;
    logic          accept;

    dcf_sync2 #(.W(PW)) u_rsync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rd_gray_x),
        .q     (rd_gray_s)
    );

    always_comb begin
        st_d      = st_q;
        rd_bin_s  = PW'(gray_to_bin(32'(rd_gray_s)));
        accept    = wr_en & ~st_q.full;
        st_d.bin  = st_q.bin + PW'(accept);
        st_d.gray = PW'(bin_to_gray(32'(st_d.bin)));
        used      = st_d.bin - rd_bin_s;
        st_d.full = (used == DEPTH_P);
        st_d.afull = ((DEPTH_P - used) <= st_q.ofs);
        if (ofs_load) st_d.ofs = ofs_value;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.ofs   <= PW'(OFS_RESET);
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_gray     = st_q.gray;
    assign wr_addr     = st_q.bin[AW-1:0];
    assign wr_accept   = accept;
    assign full        = st_q.full;
    assign almost_full = st_q.afull;

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.full && wr_en) |=> $stable(st_q.bin));

    assert_gray_one_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(st_q.gray ^ $past(st_q.gray)) <= 1));

    assert_full_warns_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.full |-> st_q.afull);
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side #(
    parameter int unsigned DEPTH     = 64,
    parameter int unsigned WIDTH     = 36,
    parameter int unsigned OFS_RESET = 8,
    localparam int unsigned PW       = $clog2(DEPTH) + 1,
    localparam int unsigned AW       = PW - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic             ofs_load,
    input  logic [PW-1:0]    ofs_value,
    input  logic [PW-1:0]    wr_gray_x,
    input  logic [WIDTH-1:0] mem_rdata,
    output logic [PW-1:0]    rd_gray,
    output logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             almost_empty
);
    import dcf_pkg::*;

    typedef struct packed {
        logic [PW-1:0]    bin;
        logic [PW-1:0]    gray;
        logic [PW-1:0]    ofs;
        logic             empty;
        logic             aempty;
        logic [WIDTH-1:0] data;
    } rd_state_t;

    rd_state_t     st_d, st_q;
    logic [PW-1:0] wr_gray_s;
    logic [PW-1:0] wr_bin_s;
    logic [PW-1:0] stored;
    logic          accept;

    dcf_sync2 #(.W(PW)) u_wsync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (wr_gray_x),
        .q     (wr_gray_s)
    );

    always_comb begin
        st_d        = st_q;
        wr_bin_s    = PW'(gray_to_bin(32'(wr_gray_s)));
        accept      = rd_en & ~st_q.empty;
        if (accept) st_d.data = mem_rdata;
        st_d.bin    = st_q.bin + PW'(accept);
        st_d.gray   = PW'(bin_to_gray(32'(st_d.bin)));
        stored      = wr_bin_s - st_d.bin;
        st_d.empty  = (stored == '0);
        st_d.aempty = (stored <= st_q.ofs);
        if (ofs_load) st_d.ofs = ofs_value;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.ofs    <= PW'(OFS_RESET);
            st_q.empty  <= 1'b1;
            st_q.aempty <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_gray      = st_q.gray;
    assign rd_addr      = st_q.bin[AW-1:0];
    assign rd_data      = st_q.data;
    assign empty        = st_q.empty;
    assign almost_empty = st_q.aempty;

    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.empty && rd_en) |=> $stable(st_q.bin));

    assert_data_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && !st_q.empty) |=> $stable(st_q.data));

    assert_empty_warns_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.empty |-> st_q.aempty);

    assert_rd_gray_one_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(st_q.gray ^ $past(st_q.gray)) <= 1));
endmodule

// File: rtl/dual_clock_fifo_thr.sv
module dual_clock_fifo_thr #(
    parameter int unsigned DEPTH     = dcf_pkg::DCF_DEPTH,
    parameter int unsigned WIDTH     = dcf_pkg::DCF_WIDTH,
    parameter int unsigned OFS_RESET = dcf_pkg::DCF_OFS_RESET,
    localparam int unsigned PW       = $clog2(DEPTH) + 1,
    localparam int unsigned AW       = PW - 1
) (
    input  logic             wr_clk,
    input  logic             wr_rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             af_load,
    input  logic [PW-1:0]    af_value,
    output logic             full,
    output logic             almost_full,
    input  logic             rd_clk,
    input  logic             rd_rst_n,
    input  logic             rd_en,
    input  logic             ae_load,
    input  logic [PW-1:0]    ae_value,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             almost_empty
);
    logic [PW-1:0]    wr_gray;
    logic [PW-1:0]    rd_gray;
    logic [AW-1:0]    wr_addr;
    logic [AW-1:0]    rd_addr;
    logic             wr_accept;
    logic [WIDTH-1:0] mem_rdata;

    dcf_wr_side #(.DEPTH(DEPTH), .OFS_RESET(OFS_RESET)) u_wr (
        .clk         (wr_clk),
        .rst_n       (wr_rst_n),
        .wr_en       (wr_en),
        .ofs_load    (af_load),
        .ofs_value   (af_value),
        .rd_gray_x   (rd_gray),
        .wr_gray     (wr_gray),
        .wr_addr     (wr_addr),
        .wr_accept   (wr_accept),
        .full        (full),
        .almost_full (almost_full)
    );

    dcf_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ram (
        .wclk  (wr_clk),
        .we    (wr_accept),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (mem_rdata)
    );

    dcf_rd_side #(.DEPTH(DEPTH), .WIDTH(WIDTH), .OFS_RESET(OFS_RESET)) u_rd (
        .clk          (rd_clk),
        .rst_n        (rd_rst_n),
        .rd_en        (rd_en),
        .ofs_load     (ae_load),
        .ofs_value    (ae_value),
        .wr_gray_x    (wr_gray),
        .mem_rdata    (mem_rdata),
        .rd_gray      (rd_gray),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .empty        (empty),
        .almost_empty (almost_empty)
    );
endmodule

// File: tb/dual_clock_fifo_thr_test.sv
`timescale 1ns/100ps
module dual_clock_fifo_thr_test;
    localparam int DEPTH = 64;
    localparam int NASYNC = 300;

    logic clk = 1'b0;
    logic aclk = 1'b0;
    logic async_mode = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [35:0] wr_data = '0;
    logic af_load = 1'b0, ae_load = 1'b0;
    logic [6:0] af_value = '0, ae_value = '0;
    logic full, almost_full, empty, almost_empty;
    logic [35:0] rd_data;
    logic rd_clk;

    int checks = 0;
    int fails = 0;
    int seq = 0;

    always #4 clk = ~clk;
    always #5.5 aclk = ~aclk;
    assign rd_clk = async_mode ? aclk : clk;

    dual_clock_fifo_thr uut (
        .wr_clk(clk), .wr_rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .af_load(af_load), .af_value(af_value), .full(full), .almost_full(almost_full),
        .rd_clk(rd_clk), .rd_rst_n(rst_n), .rd_en(rd_en), .ae_load(ae_load),
        .ae_value(ae_value), .rd_data(rd_data), .empty(empty), .almost_empty(almost_empty)
    );

    // reference model state
    logic [35:0] mq[$];
    logic [35:0] m_rdata;
    int wtot, rtot;
    int wh[4];
    int rh[4];
    logic m_full, m_af, m_empty, m_ae;
    int m_af_ofs, m_ae_ofs;

    task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        mq.delete();
        m_rdata = '0; wtot = 0; rtot = 0;
        for (int i = 0; i < 4; i++) begin wh[i] = 0; rh[i] = 0; end
        m_full = 1'b0; m_af = 1'b0; m_empty = 1'b1; m_ae = 1'b1;
        m_af_ofs = 8; m_ae_ofs = 8;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; af_load = 1'b0; ae_load = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R1: values held while in reset
        chk("R1 empty in reset", 36'(empty), 36'd1);
        chk("R1 almost_empty in reset", 36'(almost_empty), 36'd1);
        chk("R1 full in reset", 36'(full), 36'd0);
        chk("R1 almost_full in reset", 36'(almost_full), 36'd0);
        chk("R1 rd_data in reset", rd_data, 36'd0);
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // one coincident-clock cycle: model update at the edge, compare 2 ns later
    task automatic tick();
        logic acc_w, acc_r;
        @(posedge clk);
        acc_w = wr_en && !m_full;
        acc_r = rd_en && !m_empty;
        if (acc_w) begin mq.push_back(wr_data); wtot++; end
        if (acc_r) begin m_rdata = mq.pop_front(); rtot++; end
        for (int i = 3; i > 0; i--) begin wh[i] = wh[i-1]; rh[i] = rh[i-1]; end
        wh[0] = wtot; rh[0] = rtot;
        m_empty = (wh[3] == rh[0]);
        m_ae    = ((wh[3] - rh[0]) <= m_ae_ofs);
        m_full  = ((wh[0] - rh[3]) == DEPTH);
        m_af    = ((DEPTH - (wh[0] - rh[3])) <= m_af_ofs);
        if (af_load) m_af_ofs = int'(af_value);
        if (ae_load) m_ae_ofs = int'(ae_value);
        #2;
        chk("R5 empty timing", 36'(empty), 36'(m_empty));
        chk("R3/R5 full timing", 36'(full), 36'(m_full));
        chk("R6/R8 almost_empty", 36'(almost_empty), 36'(m_ae));
        chk("R7/R8 almost_full", 36'(almost_full), 36'(m_af));
        chk("R9 rd_data", rd_data, m_rdata);
    endtask

    task automatic drive(input bit we, input bit re, input int n);
        for (int k = 0; k < n; k++) begin
            wr_en = we; rd_en = re;
            wr_data = {4'(seq), 32'(seq) * 32'h9E3779B1};
            seq++;
            tick();
        end
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    initial begin
        model_reset();
        do_reset();

        // R4: reads on an empty buffer
        drive(0, 1, 4);
        chk("R4 rd_data unchanged on empty read", rd_data, 36'd0);
        chk("R4 still empty", 36'(empty), 36'd1);

        // R5: single word crossing, then read it back
        drive(1, 0, 1);
        drive(0, 0, 5);
        drive(0, 1, 2);

        // R3: fill beyond capacity
        drive(1, 0, 70);
        drive(0, 0, 4);
        chk("R3 full after 64 words", 36'(full), 36'd1);

        // R8: new thresholds
        af_load = 1'b1; af_value = 7'd20; ae_load = 1'b1; ae_value = 7'd30;
        tick();
        af_load = 1'b0; ae_load = 1'b0;
        drive(0, 1, 10);
        drive(0, 0, 4);
        chk("R8 almost_full with threshold 20 and 10 free", 36'(almost_full), 36'd1);

        // mixed traffic
        for (int k = 0; k < 40; k++) begin
            drive(k % 3 != 0, k % 2 == 0, 1);
        end

        // R2: drain all and confirm order was kept (rd_data checked each cycle)
        drive(0, 1, 80);
        drive(0, 0, 4);
        chk("R2 all words drained", 36'(mq.size()), 36'd0);
        chk("R2 empty after drain", 36'(empty), 36'd1);

        // R10: unrelated clocks
        rst_n = 1'b0;
        async_mode = 1'b1;
        do_reset();
        fork
            begin : writer
                logic pw;
                int sent;
                pw = 1'b0; sent = 0;
                while (sent < NASYNC) begin
                    @(posedge clk); #1;
                    if (pw) begin mq.push_back(wr_data); sent++; end
                    if (sent >= NASYNC) begin
                        wr_en = 1'b0; pw = 1'b0;
                    end else begin
                        wr_en = ($urandom_range(0, 3) != 0);
                        wr_data = {4'hA, 32'(sent) * 32'h01000193};
                        pw = wr_en && !full;
                    end
                end
                wr_en = 1'b0;
            end
            begin : reader
                logic pr;
                int got;
                logic [35:0] e;
                pr = 1'b0; got = 0;
                while (got < NASYNC) begin
                    @(posedge rd_clk); #1;
                    if (pr) begin
                        if (mq.size() == 0) begin
                            chk("R10 word delivered that was never accepted", rd_data, 36'hFFFFFFFFF);
                        end else begin
                            e = mq.pop_front();
                            chk("R10 async order", rd_data, e);
                        end
                        got++;
                    end
                    rd_en = (got < NASYNC) && ($urandom_range(0, 2) != 0);
                    pr = rd_en && !empty;
                end
                rd_en = 1'b0;
            end
        join
        repeat (6) @(posedge rd_clk);
        #1;
        chk("R10 empty after async drain", 36'(empty), 36'd1);
        chk("R10 no leftover words", 36'(mq.size()), 36'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule